// File: doc/BRIEF.md
# IO Wait-State Request Generator

This block sits on the peripheral side of a four-phase processor bus and drives the asynchronous ready request that feeds the clock synchronizer in front of the processor. It watches one-hot bus phase flags (first address period, second period, third period, wait period, final period), an IO-select decode and a 3-bit wait-count setting. For an IO cycle with a programmed wait count N, it holds the request low over exactly the clock periods needed so that the processor adds exactly N extra clocks.

The synchronizer delays the request by one clock. The request therefore leads the processor's sampling point by one period. It goes low in the second period of the cycle and stays low for N periods in total, covering the second period, the third period and the first N-2 wait periods. It is released one period before the last wait state. Memory cycles, unselected cycles and a wait count of zero leave the request high throughout. The wait count is captured in the first period, and the IO select is honoured only when it is seen in the first or second period.

Top module: `io_wait_gen`

## Requirements
- R1: While reset (active low) is asserted and in the first clock after it, `rdy_req` is 1.
- R2: On an IO cycle whose captured wait count is 0, `rdy_req` stays 1 in every period and the bus cycle takes four clocks.
- R3: On an IO cycle with a captured wait count of 1 to 7, `rdy_req` is 0 during the second period.
- R4: With a wait count of 1, `rdy_req` is 0 in the second period only and the cycle takes five clocks.
- R5: With a wait count of 2, `rdy_req` is 0 in the second and third periods and 1 from the first wait period on; the cycle takes six clocks.
- R6: With a wait count N from 3 to 7, `rdy_req` is 0 in the second period, the third period and wait periods 1 to N-2, and 1 from wait period N-1 on; the cycle takes 4+N clocks.
- R7: A cycle with `io_sel` low in both the first and second periods (a memory or unselected cycle) keeps `rdy_req` at 1 and takes four clocks.
- R8: `wait_cnt` is captured in the first period. A change in later periods has no effect on the current cycle.
- R9: `io_sel` is honoured when high in either the first or the second period. A select that appears only in the third period has no effect.
- R10: `rdy_req` is 1 in every first and final period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ph_t1 | input | 1 | Current period is the first (address) period |
| ph_t2 | input | 1 | Current period is the second period |
| ph_t3 | input | 1 | Current period is the third period |
| ph_tw | input | 1 | Current period is an inserted wait period |
| ph_t4 | input | 1 | Current period is the final period |
| io_sel | input | 1 | Decoded select for a slow IO device |
| wait_cnt | input | 3 | Number of wait states wanted for selected IO cycles (0 to 7) |
| rdy_req | output | 1 | Ready request to the synchronizer; 0 asks for waits |

## Verification
`rdy_req` is combinational from the phase flags and from state registered at the previous edge, so its value for a period is due in that same period. The bench drives each period just after a rising edge and samples at the falling edge. The bench models the synchronizer as a flop that copies `rdy_req` at the end of each period. It models the processor deciding between a wait period and the final period from that copy at the end of the third and wait periods, so each wait state appears one clock after the request that caused it. The clock count of each bus cycle is checked against 4+N. Every period's `rdy_req` is checked against the expected window of N low periods counted from the second period.

// File: rtl/io_wait_pkg.sv
// Package: shared widths and helpers for the IO wait-state generator.
// Assumes wait counts never exceed 2**WAIT_W - 1.
package io_wait_pkg;
    localparam int WAIT_W = 3;
    localparam int PER_W  = WAIT_W;
    localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};

    // Saturating increment for the period counter.
    function automatic logic [PER_W-1:0] sat_inc(input logic [PER_W-1:0] v);
        return (v == PER_MAX) ? v : v + 1'b1;
    endfunction
endpackage

// File: rtl/io_wait_capture.sv
// Captures the per-cycle setup: wait count in the first period, and the
// IO select seen in the first or second period. Assumes one-hot phase flags.
module io_wait_capture
    import io_wait_pkg::*;
#(
    parameter int W = WAIT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ph_t1,
    input  logic         ph_t2,
    input  logic         io_sel,
    input  logic [W-1:0] wait_cnt,
    output logic [W-1:0] cnt_q,
    output logic         sel_q
);
    // Hold the wait count taken in the first period.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (ph_t1) cnt_q <= wait_cnt;
    end

    // Remember an IO select seen in the first or second period.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= 1'b0;
        else if (ph_t1) sel_q <= io_sel;
        else if (ph_t2) sel_q <= sel_q | io_sel;
    end
endmodule

// File: rtl/io_wait_period_ctr.sv
// Counts periods elapsed since the start of the second period. It reads 0
// during the second period, 1 in the third, 2 in the first wait period, and so on.
// It saturates at its maximum and clears in the first and final periods.
module io_wait_period_ctr
    import io_wait_pkg::*;
#(
    parameter int W = PER_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ph_t1,
    input  logic         ph_t2,
    input  logic         ph_t3,
    input  logic         ph_tw,
    input  logic         ph_t4,
    output logic [W-1:0] per_q
);
    logic in_body;
    assign in_body = ph_t2 | ph_t3 | ph_tw;

    // Advance through the body of the cycle, clear at its ends.
    always_ff @(posedge clk) begin
        if (!rst_n)              per_q <= '0;
        else if (ph_t1 || ph_t4) per_q <= '0;
        else if (in_body)        per_q <= (per_q == {W{1'b1}}) ? per_q : per_q + 1'b1;
    end
endmodule

// File: rtl/io_wait_decode.sv
// Forms the ready request: low while the cycle is a selected IO cycle, the
// bus is in the second, third or a wait period, and fewer than N periods have
// passed since the second period began. High otherwise and during reset.
module io_wait_decode #(
    parameter int W = 3
) (
    input  logic         rst_n,
    input  logic         ph_t2,
    input  logic         ph_t3,
    input  logic         ph_tw,
    input  logic         io_sel,
    input  logic         sel_q,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] per_q,
    output logic         rdy_req
);
    logic active;
    logic in_body;
    logic in_window;

    // Select may still arrive during the second period itself.
    always_comb begin
        active    = sel_q | (ph_t2 & io_sel);
        in_body   = ph_t2 | ph_t3 | ph_tw;
        in_window = active & in_body & (per_q < cnt_q);
        rdy_req   = !rst_n | !in_window;
    end
endmodule

// File: rtl/io_wait_gen.sv
// Top of the IO wait-state request generator. Drives the ready request that
// feeds the clock synchronizer so that a selected IO cycle gains exactly
// wait_cnt extra clocks. Assumes one-hot phase flags from the bus controller.
module io_wait_gen
    import io_wait_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph_t1,
    input  logic              ph_t2,
    input  logic              ph_t3,
    input  logic              ph_tw,
    input  logic              ph_t4,
    input  logic              io_sel,
    input  logic [WAIT_W-1:0] wait_cnt,
    output logic              rdy_req
);
    logic [WAIT_W-1:0] cnt_q;
    logic              sel_q;
    logic [PER_W-1:0]  per_q;

    io_wait_capture #(.W(WAIT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .ph_t1(ph_t1), .ph_t2(ph_t2),
        .io_sel(io_sel), .wait_cnt(wait_cnt), .cnt_q(cnt_q), .sel_q(sel_q)
    );

    io_wait_period_ctr #(.W(PER_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .ph_t1(ph_t1), .ph_t2(ph_t2),
        .ph_t3(ph_t3), .ph_tw(ph_tw), .ph_t4(ph_t4), .per_q(per_q)
    );

    io_wait_decode #(.W(WAIT_W)) u_dec (
        .rst_n(rst_n), .ph_t2(ph_t2), .ph_t3(ph_t3), .ph_tw(ph_tw),
        .io_sel(io_sel), .sel_q(sel_q), .cnt_q(cnt_q), .per_q(per_q),
        .rdy_req(rdy_req)
    );
endmodule

// File: rtl/io_wait_gen_chk.sv
// Checker for io_wait_gen, attached by bind. Observes ports only.
module io_wait_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ph_t1,
    input logic       ph_t2,
    input logic       ph_t3,
    input logic       ph_tw,
    input logic       ph_t4,
    input logic       io_sel,
    input logic [2:0] wait_cnt,
    input logic       rdy_req
);
    // R1: request high while in reset
    a_r1_reset_high: assert property (@(posedge clk) !rst_n |-> rdy_req);

    // R10: first and final periods never ask for waits
    a_r10_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_t1 || ph_t4) |-> rdy_req);

    // R3: nonzero count on a selected cycle pulls the request low in the second period
    a_r3_low_in_t2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_t2 && $past(ph_t1) && $past(wait_cnt) != 3'd0 && ($past(io_sel) || io_sel)) |-> !rdy_req);

    // R2: zero count keeps the second period high
    a_r2_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_t2 && $past(ph_t1) && $past(wait_cnt) == 3'd0) |-> rdy_req);

    // R6: once released inside a cycle, the request stays released
    a_r6_no_relow: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph_t3 || ph_tw) && $past(rdy_req) && $past(ph_t2 || ph_t3 || ph_tw)) |-> rdy_req);

    // R9: a select seen only from the third period on is ignored
    a_r9_late_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_t3 && $past(ph_t2) && !$past(io_sel) && $past(ph_t1, 2) && !$past(io_sel, 2)) |-> rdy_req);

    // R7: unselected cycle keeps the request high in the second period
    a_r7_unsel: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_t2 && !io_sel && $past(ph_t1) && !$past(io_sel)) |-> rdy_req);
endmodule

bind io_wait_gen io_wait_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ph_t1(ph_t1), .ph_t2(ph_t2), .ph_t3(ph_t3),
    .ph_tw(ph_tw), .ph_t4(ph_t4), .io_sel(io_sel), .wait_cnt(wait_cnt),
    .rdy_req(rdy_req)
);

// File: tb/io_wait_gen_tb.sv
`timescale 1ns/1ps
// Bench: plays the processor and the synchronizer around io_wait_gen.
module io_wait_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ph_t1 = 0, ph_t2 = 0, ph_t3 = 0, ph_tw = 0, ph_t4 = 0;
    logic       io_sel = 1'b0;
    logic [2:0] wait_cnt = 3'd0;
    logic       rdy_req;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    io_wait_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ph_t1(ph_t1), .ph_t2(ph_t2), .ph_t3(ph_t3),
        .ph_tw(ph_tw), .ph_t4(ph_t4), .io_sel(io_sel), .wait_cnt(wait_cnt),
        .rdy_req(rdy_req)
    );

    // Vector: {wait count[4:2], select mode[1:0]}; mode 0 none, 1 first period,
    // 2 second period only, 3 third period only.
    localparam logic [4:0] VEC [0:13] = '{
        {3'd0, 2'd1}, {3'd1, 2'd1}, {3'd2, 2'd1}, {3'd3, 2'd1},
        {3'd4, 2'd1}, {3'd5, 2'd1}, {3'd6, 2'd1}, {3'd7, 2'd1},
        {3'd3, 2'd0}, {3'd7, 2'd0}, {3'd2, 2'd2}, {3'd5, 2'd2},
        {3'd4, 2'd3}, {3'd1, 2'd3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_ph(input int p);
        ph_t1 = (p == 1); ph_t2 = (p == 2); ph_t3 = (p == 3);
        ph_tw = (p == 5); ph_t4 = (p == 4);
    endtask

    // Run one bus cycle; the processor model decides on waits from the
    // synchronized copy of rdy_req.
    task automatic bus_cycle(input int cfg, input int mode, input bit late_cfg, input string req);
        int  n_exp;
        int  k;
        int  tw;
        bit  sync_q;
        bit  act;
        act   = (mode == 1) || (mode == 2);
        n_exp = act ? cfg : 0;
        // First period
        @(posedge clk); #1;
        set_ph(1); wait_cnt = 3'(cfg); io_sel = (mode == 1);
        @(negedge clk);
        check(rdy_req == 1'b1, "R10", rdy_req, 1);
        // Second period
        @(posedge clk); #1;
        set_ph(2); io_sel = (mode == 2);
        if (late_cfg) wait_cnt = ~3'(cfg);
        @(negedge clk);
        check(rdy_req == (0 >= n_exp), req, rdy_req, (0 >= n_exp));
        sync_q = rdy_req;
        // Third period
        @(posedge clk); #1;
        set_ph(3); io_sel = (mode == 3);
        @(negedge clk);
        check(rdy_req == (1 >= n_exp), req, rdy_req, (1 >= n_exp));
        k  = 2;
        tw = 0;
        // Wait periods while synchronized ready is low
        while (!sync_q && tw < 12) begin
            sync_q = rdy_req;
            @(posedge clk); #1;
            set_ph(5); io_sel = 1'b0;
            @(negedge clk);
            check(rdy_req == (k >= n_exp), req, rdy_req, (k >= n_exp));
            k++;
            tw++;
        end
        // Final period
        @(posedge clk); #1;
        set_ph(4); io_sel = 1'b0;
        @(negedge clk);
        check(rdy_req == 1'b1, "R10", rdy_req, 1);
        check(tw == n_exp, req, 4 + tw, 4 + n_exp);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        string tag;
        // R1: reset state, even with a selected second period showing
        set_ph(2); io_sel = 1'b1; wait_cnt = 3'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rdy_req == 1'b1, "R1", rdy_req, 1);
        @(posedge clk); #1;
        set_ph(0); io_sel = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check(rdy_req == 1'b1, "R1", rdy_req, 1);

        // Table walk (R2 R3 R4 R5 R6 R7 R9)
        foreach (VEC[i]) begin
            int c;
            int m;
            c = int'(VEC[i][4:2]);
            m = int'(VEC[i][1:0]);
            if (m == 0)                     tag = "R7";
            else if (m == 3)                tag = "R9";
            else if (c == 0)                tag = "R2";
            else if (c == 1)                tag = "R4";
            else if (c == 2)                tag = "R5";
            else                            tag = "R6";
            bus_cycle(c, m, 1'b0, tag);
        end

        // R8: count changed after the first period does not alter this cycle
        bus_cycle(2, 1, 1'b1, "R8");
        bus_cycle(0, 1, 1'b1, "R8");
        // R3: nonzero count with select from the second period only
        bus_cycle(1, 2, 1'b0, "R3");
        // Back-to-back zero cycle after a long one (R2)
        bus_cycle(7, 1, 1'b0, "R6");
        bus_cycle(0, 2, 1'b0, "R2");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule